// File: doc/BRIEF.md
# Double to Single Precision Narrowing Unit

This block narrows one IEEE-754 binary64 value to binary32. The binary64 operand sits in the low 64 bits of the second 128-bit source (`src2`). The binary32 result is placed in bits 31:0 of a 256-bit destination. The five exception conditions for that one operation are reported next to the result on a 5-bit flag vector. The caller accumulates these flags if it needs them sticky. Rounding follows a 2-bit rounding-control input. Signalling NaNs are quietened. Overflow saturates to infinity or to the largest finite value, depending on the rounding direction and the sign. Values too small for the normal range are rounded into the subnormal range or to zero.

The upper 224 destination bits come from one of two merge rules, chosen by `merge_mode`. The legacy rule keeps the previous destination contents. The three-operand rule copies bits 127:32 of the first source (`src1`) and clears bits 255:128.

All results and flags are registered, so `out_valid` follows `in_valid` by exactly one clock.

Top module: `dp2sp_narrow`

## Requirements
- R1: The operand is `src2[63:0]` (`src2[127:64]` is ignored). A representable value produces its exact binary32 encoding in `result[31:0]`.
- R2: `rnd_mode` encoding: 00 = nearest-even, 01 = toward minus infinity, 10 = toward plus infinity, 11 = toward zero. Inexact finite results round accordingly, including a carry into the exponent.
- R3: On overflow the result is determined by the rounding mode and the sign. It is infinity under nearest-even, and under a directed mode that points away from zero. Otherwise it is the largest finite binary32 value of that sign. Overflow and precision are both raised.
- R4: A result is tiny when the unrounded magnitude is below 2^-126. A tiny result is rounded at subnormal precision and may become zero or the smallest normal. Underflow is raised only for results that are both tiny and inexact.
- R5: A subnormal binary64 operand raises the denormal flag.
- R6: A signalling NaN (exponent all ones, fraction nonzero, fraction MSB 0) raises invalid. A quiet NaN raises nothing. For both, the result keeps the sign and the upper 22 payload bits, and has the quiet bit (bit 22) set.
- R7: Infinities and zeros convert exactly, keep their sign and raise no flag.
- R8: With `merge_mode` = 0 (legacy), `result[255:32]` equals the previous destination `dest_old[255:32]`.
- R9: With `merge_mode` = 1 (three-operand), `result[127:32]` equals `src1[127:32]` and `result[255:128]` is zero.
- R10: `out_valid` is low in reset. It rises exactly one cycle after each `in_valid` cycle and is low otherwise.
- R11: Flag positions: `flags[0]` invalid, `flags[1]` denormal, `flags[2]` overflow, `flags[3]` underflow, `flags[4]` precision. Precision is raised whenever the delivered result differs from the exact value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| merge_mode | input | 1 | 0 legacy merge, 1 three-operand merge |
| src1 | input | 128 | First source, supplies bits 127:32 in three-operand mode |
| src2 | input | 128 | Second source, binary64 operand in bits 63:0 |
| dest_old | input | 256 | Previous destination contents |
| rnd_mode | input | 2 | Rounding control |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 256 | Merged destination value |
| flags | output | 5 | Exception flags of this operation |

## Verification
The lane-merge assertions compare the output with the inputs of the previous cycle. They therefore rely on `merge_mode`, `src1` and `dest_old` being stable at the clock edge where `in_valid` is sampled. The stimulus drives all inputs on the falling edge and holds them through the following rising edge.

The flag-consistency assertions look only at the output. They rely on `out_valid` being high only when `in_valid` was high with `rst` low on the previous edge. The stimulus therefore keeps `in_valid` low throughout reset.

// File: rtl/dp2sp_pkg.sv
package dp2sp_pkg;

    localparam int DP_W       = 64;
    localparam int DP_EXP_W   = 11;
    localparam int DP_FRAC_W  = 52;
    localparam int DP_MANT_W  = DP_FRAC_W + 1;
    localparam int SP_W       = 32;
    localparam int SP_EXP_W   = 8;
    localparam int SP_FRAC_W  = 23;
    localparam int SP_MANT_W  = SP_FRAC_W + 1;
    localparam int EXP_CALC_W = 13;
    localparam int SHIFT_MAX  = 32;
    localparam int PAYLOAD_W  = SP_FRAC_W - 1;
    localparam int FLAG_W     = 5;

    localparam int DP_BIAS = 1023;
    localparam int SP_BIAS = 127;
    localparam logic signed [EXP_CALC_W-1:0] REBIAS = EXP_CALC_W'(DP_BIAS - SP_BIAS);
    localparam logic signed [EXP_CALC_W-1:0] SP_EXP_OVF = EXP_CALC_W'((1 << SP_EXP_W) - 1);

    localparam int FLG_INVALID   = 0;
    localparam int FLG_DENORMAL  = 1;
    localparam int FLG_OVERFLOW  = 2;
    localparam int FLG_UNDERFLOW = 3;
    localparam int FLG_PRECISION = 4;

    typedef enum logic [1:0] {
        RND_NEAREST = 2'b00,
        RND_DOWN    = 2'b01,
        RND_UP      = 2'b10,
        RND_ZERO    = 2'b11
    } rnd_mode_e;

    typedef enum logic {
        MERGE_LEGACY = 1'b0,
        MERGE_3OP    = 1'b1
    } merge_mode_e;

    typedef struct packed {
        logic                          sign;
        logic                          is_nan;
        logic                          is_snan;
        logic                          is_inf;
        logic                          is_zero;
        logic                          is_sub;
        logic signed [EXP_CALC_W-1:0]  sp_exp;
        logic [DP_MANT_W-1:0]          mant;
        logic [PAYLOAD_W-1:0]          payload;
    } dp_class_t;

    function automatic logic round_inc(rnd_mode_e mode, logic sign, logic lsb,
                                       logic guard, logic sticky);
        case (mode)
            RND_NEAREST: return guard & (sticky | lsb);
            RND_DOWN:    return (guard | sticky) & sign;
            RND_UP:      return (guard | sticky) & ~sign;
            default:     return 1'b0;
        endcase
    endfunction

    function automatic logic ovf_to_inf(rnd_mode_e mode, logic sign);
        case (mode)
            RND_NEAREST: return 1'b1;
            RND_DOWN:    return sign;
            RND_UP:      return ~sign;
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dp2sp_classify.sv
module dp2sp_classify
    import dp2sp_pkg::*;
(
    input  logic [DP_W-1:0] dp_in,
    output dp_class_t       cls
);

    logic [DP_EXP_W-1:0]  exp_f;
    logic [DP_FRAC_W-1:0] frac_f;
    logic                 exp_max;
    logic                 exp_min;
    logic                 frac_nz;

    always_comb begin
        exp_f   = dp_in[DP_W-2 -: DP_EXP_W];
        frac_f  = dp_in[DP_FRAC_W-1:0];
        exp_max = &exp_f;
        exp_min = ~|exp_f;
        frac_nz = |frac_f;

        cls.sign    = dp_in[DP_W-1];
        cls.is_nan  = exp_max & frac_nz;
        cls.is_snan = exp_max & frac_nz & ~frac_f[DP_FRAC_W-1];
        cls.is_inf  = exp_max & ~frac_nz;
        cls.is_zero = exp_min & ~frac_nz;
        cls.is_sub  = exp_min & frac_nz;
        cls.sp_exp  = (exp_min ? EXP_CALC_W'(1)
                               : $signed({{(EXP_CALC_W-DP_EXP_W){1'b0}}, exp_f}))
                      - REBIAS;
        cls.mant    = {~exp_min, frac_f};
        cls.payload = frac_f[DP_FRAC_W-2 -: PAYLOAD_W];
    end

endmodule

// File: rtl/dp2sp_round.sv
module dp2sp_round
    import dp2sp_pkg::*;
(
    input  dp_class_t         cls,
    input  rnd_mode_e         rmode,
    output logic [SP_W-1:0]   sp_out,
    output logic [FLAG_W-1:0] flg_out
);

    localparam int WIDE_W = DP_MANT_W + SHIFT_MAX;
    localparam int SH_W   = $clog2(SHIFT_MAX + 1);

    logic signed [EXP_CALC_W-1:0] need_sh;
    logic [SH_W-1:0]              sh;
    logic [WIDE_W-1:0]            wide;
    logic [SP_MANT_W-1:0]         kept;
    logic                         guard;
    logic                         sticky;
    logic                         inc;
    logic [SP_MANT_W:0]           rounded;
    logic                         tiny;
    logic                         inexact;
    logic signed [EXP_CALC_W-1:0] exp_out;
    logic                         ovf;
    logic [SP_W-1:0]              finite_val;
    logic [SP_W-1:0]              ovf_val;

    always_comb begin
        need_sh = EXP_CALC_W'(1) - cls.sp_exp;
        tiny    = cls.sp_exp < EXP_CALC_W'(1);
        if (!tiny)
            sh = '0;
        else if (need_sh > EXP_CALC_W'(SHIFT_MAX))
            sh = SH_W'(SHIFT_MAX);
        else
            sh = need_sh[SH_W-1:0];

        wide    = {cls.mant, {SHIFT_MAX{1'b0}}} >> sh;
        kept    = wide[WIDE_W-1 -: SP_MANT_W];
        guard   = wide[WIDE_W-1-SP_MANT_W];
        sticky  = |wide[WIDE_W-2-SP_MANT_W:0];
        inexact = guard | sticky;
        inc     = round_inc(rmode, cls.sign, kept[0], guard, sticky);
        rounded = {1'b0, kept} + (SP_MANT_W+1)'(inc);

        exp_out = cls.sp_exp
                  + $signed({{(EXP_CALC_W-1){1'b0}}, rounded[SP_MANT_W]});
        ovf     = ~tiny & (exp_out >= SP_EXP_OVF);

        if (tiny)
            finite_val = {cls.sign, {(SP_EXP_W-1){1'b0}}, rounded[SP_FRAC_W],
                          rounded[SP_FRAC_W-1:0]};
        else
            finite_val = {cls.sign, exp_out[SP_EXP_W-1:0], rounded[SP_FRAC_W-1:0]};

        if (ovf_to_inf(rmode, cls.sign))
            ovf_val = {cls.sign, {SP_EXP_W{1'b1}}, {SP_FRAC_W{1'b0}}};
        else
            ovf_val = {cls.sign, {(SP_EXP_W-1){1'b1}}, 1'b0, {SP_FRAC_W{1'b1}}};

        flg_out = '0;
        if (cls.is_nan) begin
            sp_out = {cls.sign, {SP_EXP_W{1'b1}}, 1'b1, cls.payload};
            flg_out[FLG_INVALID] = cls.is_snan;
        end else if (cls.is_inf) begin
            sp_out = {cls.sign, {SP_EXP_W{1'b1}}, {SP_FRAC_W{1'b0}}};
        end else if (cls.is_zero) begin
            sp_out = {cls.sign, {(SP_W-1){1'b0}}};
        end else begin
            flg_out[FLG_DENORMAL] = cls.is_sub;
            if (ovf) begin
                sp_out = ovf_val;
                flg_out[FLG_OVERFLOW]  = 1'b1;
                flg_out[FLG_PRECISION] = 1'b1;
            end else begin
                sp_out = finite_val;
                flg_out[FLG_UNDERFLOW] = tiny & inexact;
                flg_out[FLG_PRECISION] = inexact;
            end
        end
    end

endmodule

// File: rtl/dp2sp_lane_merge.sv
module dp2sp_lane_merge
    import dp2sp_pkg::*;
#(
    parameter int LANE_W = 128,
    parameter int RES_W  = 256
) (
    input  merge_mode_e       mode,
    input  logic [SP_W-1:0]   sp_val,
    input  logic [LANE_W-1:0] src1,
    input  logic [RES_W-1:0]  dest_old,
    output logic [RES_W-1:0]  merged
);

    localparam int HI_W = RES_W - LANE_W;

    always_comb begin
        if (mode == MERGE_LEGACY)
            merged = {dest_old[RES_W-1:SP_W], sp_val};
        else
            merged = {{HI_W{1'b0}}, src1[LANE_W-1:SP_W], sp_val};
    end

endmodule

// File: rtl/dp2sp_narrow.sv
module dp2sp_narrow
    import dp2sp_pkg::*;
#(
    parameter int LANE_W = 128,
    parameter int RES_W  = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              merge_mode,
    input  logic [LANE_W-1:0] src1,
    input  logic [LANE_W-1:0] src2,
    input  logic [RES_W-1:0]  dest_old,
    input  logic [1:0]        rnd_mode,
    output logic              out_valid,
    output logic [RES_W-1:0]  result,
    output logic [FLAG_W-1:0] flags
);

    dp_class_t         cls;
    logic [SP_W-1:0]   sp_val;
    logic [FLAG_W-1:0] flg_val;
    logic [RES_W-1:0]  merged;

    dp2sp_classify u_classify (
        .dp_in (src2[DP_W-1:0]),
        .cls   (cls)
    );

    dp2sp_round u_round (
        .cls     (cls),
        .rmode   (rnd_mode_e'(rnd_mode)),
        .sp_out  (sp_val),
        .flg_out (flg_val)
    );

    dp2sp_lane_merge #(
        .LANE_W (LANE_W),
        .RES_W  (RES_W)
    ) u_merge (
        .mode     (merge_mode_e'(merge_mode)),
        .sp_val   (sp_val),
        .src1     (src1),
        .dest_old (dest_old),
        .merged   (merged)
    );

    always_ff @(posedge clk) begin
        if (rst)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            result <= merged;
            flags  <= flg_val;
        end
    end

endmodule

// File: rtl/dp2sp_narrow_chk.sv
module dp2sp_narrow_chk
    import dp2sp_pkg::*;
#(
    parameter int LANE_W = 128,
    parameter int RES_W  = 256
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              merge_mode,
    input logic [LANE_W-1:0] src1,
    input logic [RES_W-1:0]  dest_old,
    input logic              out_valid,
    input logic [RES_W-1:0]  result,
    input logic [FLAG_W-1:0] flags
);

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    legacy_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(merge_mode)) |->
            result[RES_W-1:SP_W] == $past(dest_old[RES_W-1:SP_W]));

    // R9
    threeop_mid_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(merge_mode)) |->
            result[LANE_W-1:SP_W] == $past(src1[LANE_W-1:SP_W]));

    // R9
    threeop_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(merge_mode)) |-> result[RES_W-1:LANE_W] == '0);

    // R3
    overflow_precision_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flags[FLG_OVERFLOW]) |-> flags[FLG_PRECISION]);

    // R4
    underflow_precision_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flags[FLG_UNDERFLOW]) |-> flags[FLG_PRECISION]);

    // R6
    invalid_nan_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flags[FLG_INVALID]) |->
            (result[SP_W-2:SP_FRAC_W-1] == '1 && $countones(flags) == 1));

endmodule

bind dp2sp_narrow dp2sp_narrow_chk #(
    .LANE_W (LANE_W),
    .RES_W  (RES_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .merge_mode (merge_mode),
    .src1       (src1),
    .dest_old   (dest_old),
    .out_valid  (out_valid),
    .result     (result),
    .flags      (flags)
);

// File: tb/dp2sp_narrow_tb.sv
`timescale 1ns/1ps
module dp2sp_narrow_tb;

    localparam int NVEC = 27;
    // {req[7:0], double[63:0], rnd[1:0], single[31:0], flags[4:0]}
    // flags: [0] invalid [1] denormal [2] overflow [3] underflow [4] precision
    localparam logic [110:0] VEC [NVEC] = '{
        {8'd1,  64'h3FF0000000000000, 2'd0, 32'h3F800000, 5'h00}, // R1
        {8'd1,  64'hC004000000000000, 2'd0, 32'hC0200000, 5'h00}, // R1
        {8'd2,  64'h3FD5555555555555, 2'd0, 32'h3EAAAAAB, 5'h10}, // R2
        {8'd2,  64'h3FD5555555555555, 2'd3, 32'h3EAAAAAA, 5'h10}, // R2
        {8'd2,  64'h3FD5555555555555, 2'd2, 32'h3EAAAAAB, 5'h10}, // R2
        {8'd2,  64'h3FD5555555555555, 2'd1, 32'h3EAAAAAA, 5'h10}, // R2
        {8'd2,  64'hBFD5555555555555, 2'd1, 32'hBEAAAAAB, 5'h10}, // R2
        {8'd2,  64'hBFD5555555555555, 2'd2, 32'hBEAAAAAA, 5'h10}, // R2
        {8'd3,  64'h7FEFFFFFFFFFFFFF, 2'd0, 32'h7F800000, 5'h14}, // R3
        {8'd3,  64'h7FEFFFFFFFFFFFFF, 2'd3, 32'h7F7FFFFF, 5'h14}, // R3
        {8'd3,  64'hFFEFFFFFFFFFFFFF, 2'd2, 32'hFF7FFFFF, 5'h14}, // R3
        {8'd3,  64'hFFEFFFFFFFFFFFFF, 2'd1, 32'hFF800000, 5'h14}, // R3
        {8'd7,  64'h7FF0000000000000, 2'd0, 32'h7F800000, 5'h00}, // R7
        {8'd7,  64'hFFF0000000000000, 2'd3, 32'hFF800000, 5'h00}, // R7
        {8'd7,  64'h8000000000000000, 2'd0, 32'h80000000, 5'h00}, // R7
        {8'd6,  64'h7FF4000000000000, 2'd0, 32'h7FE00000, 5'h01}, // R6
        {8'd6,  64'hFFF8000000000001, 2'd0, 32'hFFC00000, 5'h00}, // R6
        {8'd5,  64'h0000000000000001, 2'd0, 32'h00000000, 5'h1A}, // R5
        {8'd5,  64'h0000000000000001, 2'd2, 32'h00000001, 5'h1A}, // R5
        {8'd4,  64'h36A0000000000000, 2'd0, 32'h00000001, 5'h00}, // R4
        {8'd4,  64'h3690000000000000, 2'd0, 32'h00000000, 5'h18}, // R4
        {8'd4,  64'h3690000000000000, 2'd2, 32'h00000001, 5'h18}, // R4
        {8'd2,  64'h3FFFFFFFFFFFFFFF, 2'd0, 32'h40000000, 5'h10}, // R2
        {8'd11, 64'h3FFFFFFFFFFFFFFF, 2'd3, 32'h3FFFFFFF, 5'h10}, // R11
        {8'd4,  64'h380FFFFFFFFFFFFF, 2'd0, 32'h00800000, 5'h18}, // R4
        {8'd4,  64'h380FFFFFFFFFFFFF, 2'd3, 32'h007FFFFF, 5'h18}, // R4
        {8'd1,  64'h47EFFFFFE0000000, 2'd0, 32'h7F7FFFFF, 5'h00}  // R1
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         merge_mode;
    logic [127:0] src1;
    logic [127:0] src2;
    logic [255:0] dest_old;
    logic [1:0]   rnd_mode;
    logic         out_valid;
    logic [255:0] result;
    logic [4:0]   flags;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    dp2sp_narrow u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .merge_mode (merge_mode),
        .src1       (src1),
        .src2       (src2),
        .dest_old   (dest_old),
        .rnd_mode   (rnd_mode),
        .out_valid  (out_valid),
        .result     (result),
        .flags      (flags)
    );

    task automatic check(input bit ok, input string req,
                         input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [63:0] dp, input logic [1:0] rm,
                         input logic mode, input logic [127:0] s1,
                         input logic [255:0] dold);
        @(negedge clk);
        src2       = {64'hDEAD_BEEF_0BAD_F00D, dp};
        src1       = s1;
        dest_old   = dold;
        rnd_mode   = rm;
        merge_mode = mode;
        in_valid   = 1'b1;
        @(negedge clk);
        in_valid   = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst        = 1'b1;
        in_valid   = 1'b0;
        merge_mode = 1'b0;
        src1       = '0;
        src2       = '0;
        dest_old   = '0;
        rnd_mode   = 2'd0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(out_valid == 1'b0, "R10 reset", 256'(out_valid), 256'd0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R10 idle", 256'(out_valid), 256'd0);

        // Vector walk in legacy mode; upper bits checked against R8
        for (int i = 0; i < NVEC; i++) begin
            logic [255:0] dold;
            logic [127:0] s1;
            dold = {8{32'hA5A50000 + 32'(i)}};
            s1   = {4{32'h3C3C0000 + 32'(i)}};
            issue(VEC[i][102:39], VEC[i][38:37], 1'b0, s1, dold);
            check(out_valid == 1'b1, "R10 valid", 256'(out_valid), 256'd1);
            if (result[31:0] !== VEC[i][36:5])
                $display("  vector %0d R%0d", i, VEC[i][110:103]);
            check(result[31:0] === VEC[i][36:5], $sformatf("R%0d value", VEC[i][110:103]),
                  256'(result[31:0]), 256'(VEC[i][36:5]));
            check(flags === VEC[i][4:0], $sformatf("R%0d/R11 flags", VEC[i][110:103]),
                  256'(flags), 256'(VEC[i][4:0]));
            check(result[255:32] === dold[255:32], "R8 legacy merge",
                  256'(result[255:32]), 256'(dold[255:32]));
        end

        // R10: output valid drops one cycle after the strobe
        @(negedge clk);
        check(out_valid == 1'b0, "R10 single pulse", 256'(out_valid), 256'd0);

        // R9: three-operand merge
        issue(64'h3FF0000000000000, 2'd0, 1'b1,
              128'h0123456789ABCDEF_FEDCBA9876543210, {8{32'hFFFFFFFF}});
        check(result[31:0] === 32'h3F800000, "R1 value in 3-op mode",
              256'(result[31:0]), 256'h3F800000);
        check(result[127:32] === 96'h0123456789ABCDEF_FEDCBA98, "R9 middle lanes",
              256'(result[127:32]), 256'(96'h0123456789ABCDEF_FEDCBA98));
        check(result[255:128] === '0, "R9 upper zero",
              256'(result[255:128]), 256'd0);

        // R9 with a NaN operand: flags and merge together (R6)
        issue(64'hFFF0000000000003, 2'd1, 1'b1,
              {4{32'h11223344}}, {8{32'h55555555}});
        check(result[31:0] === 32'hFFC00000, "R6 snan quietened",
              256'(result[31:0]), 256'hFFC00000);
        check(flags === 5'h01, "R6 invalid only", 256'(flags), 256'h01);
        check(result[255:128] === '0, "R9 upper zero nan",
              256'(result[255:128]), 256'd0);

        // R10: back-to-back strobes
        @(negedge clk);
        src2     = {64'h0, 64'h4000000000000000};
        rnd_mode = 2'd0;
        merge_mode = 1'b0;
        dest_old = '1;
        in_valid = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b1 && result[31:0] === 32'h40000000, "R10 back-to-back first",
              256'(result[31:0]), 256'h40000000);
        src2 = {64'h0, 64'hC000000000000000};
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1 && result[31:0] === 32'hC0000000, "R10 back-to-back second",
              256'(result[31:0]), 256'hC0000000);
        @(negedge clk);
        check(out_valid == 1'b0, "R10 drop after burst", 256'(out_valid), 256'd0);

        // R10: reset in the middle clears valid
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R10 reset clears", 256'(out_valid), 256'd0);
        rst = 1'b0;
        @(negedge clk);

        finish_run();
    end

endmodule